// File: doc/BRIEF.md
# Current Averager and Charge Integrator

This block turns a stream of signed current-sense samples into two results. The first is a 12-bit signed current register: each value is the block average of 2^N_LOG2 samples (128 by default), minus a signed offset bias, and it is clamped to the register's range. The second is a 16-bit signed charge accumulator. After each new current value is formed, the block adds that value, scaled by the exact fixed-point factor SCALE_MUL / 2^FRAC_W, to the accumulator. A fractional residue keeps the part of the charge below one LSB from one update to the next.

Samples arrive on a valid/ready stream. The block never applies back-pressure. `s_ready` is low only while `rst` is high, and every cycle in which `s_valid` and `s_ready` are both high delivers one sample. The producer may leave gaps by lowering `s_valid`. Idle cycles are not counted toward a block. The host can overwrite the accumulator one byte at a time. `upd` pulses once for each new result pair.

Top module: `cur_integrator`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cur_out`, `acc_out` and `upd` are 0 and the residue is 0. The reset is synchronous and active high.
- R2: `cur_out` changes only at the clock edge that accepts the 2^N_LOG2-th sample of a block. Cycles with `s_valid` low are not counted, and `cur_out` holds its value between updates.
- R3: The new `cur_out` equals floor(sum of the block's samples / 2^N_LOG2) minus `bias`, in two's complement. `s_data` is signed 14 bits and `bias` is signed 8 bits, both in `cur_out` LSBs. A positive value means charge and a negative value means discharge.
- R4: A result above 2047 is reported as 2047, and a result below -2048 is reported as -2048.
- R5: `upd` is high for exactly one cycle: the cycle after `cur_out` took its new value. During that cycle `acc_out` already includes the new value's contribution.
- R6: On each integration, total = residue + cur_out*SCALE_MUL. The accumulator adds floor(total / 2^FRAC_W), and the residue becomes total mod 2^FRAC_W, which lies between 0 and 2^FRAC_W-1. No charge is lost, so k updates at a constant current c add exactly floor(k*c*SCALE_MUL/2^FRAC_W).
- R7: The accumulator saturates at 32767 and -32768 and never wraps.
- R8: `acc_we[1]` loads `acc_wdata[15:8]` into the accumulator's MSB byte. `acc_we[0]` loads `acc_wdata[7:0]` into its LSB byte. A byte that is not written keeps its value.
- R9: If a host write falls in the same cycle as an integration, the write wins. That integration step is discarded, the residue is left unchanged, and `upd` still pulses.
- R10: `s_ready` is high in every cycle in which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (low only in reset) |
| s_data | input | 14 | Signed current sample |
| bias | input | 8 | Signed offset subtracted from each average |
| acc_we | input | 2 | Host byte write enables for the accumulator |
| acc_wdata | input | 16 | Host write data for the accumulator |
| cur_out | output | 12 | Averaged, offset-corrected, clamped current |
| acc_out | output | 16 | Signed charge accumulator |
| upd | output | 1 | One-cycle pulse after each new result |

## Verification
The bench builds the block with N_LOG2=3, FRAC_W=4 and SCALE_MUL=45. With 8-sample blocks, dozens of updates fit in a short run. A factor of 45/16 leaves a residue that is not zero on most steps, so the carry of sub-LSB charge is exposed over 16 consecutive unit-current updates. A full-scale current moves the accumulator by about 5757 per update, so both saturation limits can be reached in a few blocks after a host preload. The same short blocks make it easy to line up a host write with an integration edge.

// File: rtl/cint_pkg.sv
package cint_pkg;
  localparam int CINT_SAMPLE_W = 14;
  localparam int CINT_CUR_W    = 12;
  localparam int CINT_BIAS_W   = 8;
  localparam int CINT_ACC_W    = 16;
  localparam int CINT_N_LOG2   = 7;
  localparam int CINT_FRAC_W   = 8;
  localparam int CINT_SCALE_W  = 8;
  localparam int CINT_SCALE    = 64;
endpackage

// File: rtl/cint_avg.sv
module cint_avg #(
  parameter int SAMPLE_W = 14,
  parameter int N_LOG2   = 7,
  parameter int BIAS_W   = 8,
  parameter int CUR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_data,
  input  logic signed [BIAS_W-1:0]   bias,
  output logic signed [CUR_W-1:0]    cur_q,
  output logic                       fire_q
);
  localparam int SUM_W  = SAMPLE_W + N_LOG2;
  localparam int DIFF_W = SUM_W + 1;
  localparam logic [N_LOG2-1:0] CNT_LAST = '1;
  localparam logic signed [DIFF_W-1:0] HI_LIM = DIFF_W'((64'sd1 <<< (CUR_W-1)) - 64'sd1);
  localparam logic signed [DIFF_W-1:0] LO_LIM = ~HI_LIM;

  logic [N_LOG2-1:0]        cnt_q;
  logic signed [SUM_W-1:0]  sum_q, sum_nx, avg;
  logic signed [DIFF_W-1:0] diff;
  logic signed [CUR_W-1:0]  cur_nx;
  logic                     last;

  always_comb begin
    sum_nx = sum_q + {{N_LOG2{in_data[SAMPLE_W-1]}}, in_data};
    avg    = sum_nx >>> N_LOG2;
    diff   = {avg[SUM_W-1], avg} - {{(DIFF_W-BIAS_W){bias[BIAS_W-1]}}, bias};
    if (diff > HI_LIM)      cur_nx = HI_LIM[CUR_W-1:0];
    else if (diff < LO_LIM) cur_nx = LO_LIM[CUR_W-1:0];
    else                    cur_nx = diff[CUR_W-1:0];
    last = in_valid && (cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      cur_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= last;
      if (in_valid) begin
        cnt_q <= cnt_q + N_LOG2'(1);
        sum_q <= last ? '0 : sum_nx;
        if (last) cur_q <= cur_nx;
      end
    end
  end

  // Register moves only on the block's final accepted sample
  assert_cur_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && cnt_q == CNT_LAST) |=> $stable(cur_q));
  assert_fire_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);
endmodule

// File: rtl/cint_acc.sv
module cint_acc #(
  parameter int CUR_W     = 12,
  parameter int ACC_W     = 16,
  parameter int FRAC_W    = 8,
  parameter int SCALE_W   = 8,
  parameter int SCALE_MUL = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_en,
  input  logic signed [CUR_W-1:0] cur,
  input  logic [ACC_W/8-1:0]      we,
  input  logic [ACC_W-1:0]        wdata,
  output logic signed [ACC_W-1:0] acc_q,
  output logic                    upd_q
);
  localparam int NB = ACC_W / 8;
  localparam int PW = CUR_W + SCALE_W + 1;
  localparam int TW = PW + 1;
  localparam int SW = TW + ACC_W;
  localparam logic signed [PW-1:0] SCALE_S = PW'(SCALE_MUL);
  localparam logic signed [SW-1:0] HI_LIM  = SW'((64'sd1 <<< (ACC_W-1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO_LIM  = ~HI_LIM;

  logic [FRAC_W-1:0]       res_q;
  logic signed [PW-1:0]    cur_x, prod;
  logic signed [TW-1:0]    tot, step;
  logic signed [SW-1:0]    sum;
  logic signed [ACC_W-1:0] acc_sat;
  logic [ACC_W-1:0]        merged;
  logic                    host_wr;

  always_comb begin
    cur_x = {{(PW-CUR_W){cur[CUR_W-1]}}, cur};
    prod  = cur_x * SCALE_S;
    tot   = {prod[PW-1], prod} + {{(TW-FRAC_W){1'b0}}, res_q};
    step  = tot >>> FRAC_W;
    sum   = {{(SW-ACC_W){acc_q[ACC_W-1]}}, acc_q} + {{(SW-TW){step[TW-1]}}, step};
    if (sum > HI_LIM)      acc_sat = HI_LIM[ACC_W-1:0];
    else if (sum < LO_LIM) acc_sat = LO_LIM[ACC_W-1:0];
    else                   acc_sat = sum[ACC_W-1:0];
    host_wr = |we;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign merged[b*8 +: 8] = we[b] ? wdata[b*8 +: 8] : acc_q[b*8 +: 8];

    assert_byte_wr_R8: assert property (@(posedge clk) disable iff (rst)
      we[b] |=> acc_q[b*8 +: 8] == $past(wdata[b*8 +: 8]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= step_en;
      if (host_wr) begin
        acc_q <= merged;
      end else if (step_en) begin
        acc_q <= acc_sat;
        res_q <= tot[FRAC_W-1:0];
      end
    end
  end

  assert_res_keep_R9: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> $stable(res_q));
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !host_wr) |=> $stable(acc_q));
  assert_acc_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (step_en && !host_wr && acc_q == HI_LIM[ACC_W-1:0] && !step[TW-1])
      |=> acc_q == $past(acc_q));
endmodule

// File: rtl/cur_integrator.sv
module cur_integrator
  import cint_pkg::*;
#(
  parameter int SAMPLE_W  = CINT_SAMPLE_W,
  parameter int CUR_W     = CINT_CUR_W,
  parameter int BIAS_W    = CINT_BIAS_W,
  parameter int ACC_W     = CINT_ACC_W,
  parameter int N_LOG2    = CINT_N_LOG2,
  parameter int FRAC_W    = CINT_FRAC_W,
  parameter int SCALE_W   = CINT_SCALE_W,
  parameter int SCALE_MUL = CINT_SCALE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic [BIAS_W-1:0]   bias,
  input  logic [ACC_W/8-1:0]  acc_we,
  input  logic [ACC_W-1:0]    acc_wdata,
  output logic [CUR_W-1:0]    cur_out,
  output logic [ACC_W-1:0]    acc_out,
  output logic                upd
);
  logic                    take;
  logic                    fire;
  logic signed [CUR_W-1:0] cur_v;
  logic signed [ACC_W-1:0] acc_v;

  assign s_ready = !rst;
  assign take    = s_valid && s_ready;

  cint_avg #(
    .SAMPLE_W(SAMPLE_W), .N_LOG2(N_LOG2), .BIAS_W(BIAS_W), .CUR_W(CUR_W)
  ) u_avg (
    .clk(clk), .rst(rst), .in_valid(take), .in_data(s_data),
    .bias(bias), .cur_q(cur_v), .fire_q(fire)
  );

  cint_acc #(
    .CUR_W(CUR_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W),
    .SCALE_W(SCALE_W), .SCALE_MUL(SCALE_MUL)
  ) u_acc (
    .clk(clk), .rst(rst), .step_en(fire), .cur(cur_v),
    .we(acc_we), .wdata(acc_wdata), .acc_q(acc_v), .upd_q(upd)
  );

  assign cur_out = cur_v;
  assign acc_out = acc_v;

  assert_upd_single_R5: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);
  assert_upd_after_cur_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(upd) |-> $stable(cur_out));
endmodule

// File: tb/sim_cur_integrator.sv
module sim_cur_integrator;
  localparam int NL = 3;
  localparam int FR = 4;
  localparam int SC = 45;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [13:0] s_data = '0;
  logic [7:0]  bias = '0;
  logic [1:0]  acc_we = '0;
  logic [15:0] acc_wdata = '0;
  logic [11:0] cur_out;
  logic [15:0] acc_out;
  logic        upd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cur_integrator #(.N_LOG2(NL), .FRAC_W(FR), .SCALE_MUL(SC)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .bias(bias), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .cur_out(cur_out), .acc_out(acc_out), .upd(upd)
  );

  // Behavioural reference
  int m_cur, m_acc, m_res, m_sum, m_cnt, m_upd;
  bit m_pend, started;

  always @(posedge clk) begin
    if (rst) begin
      m_cur = 0; m_acc = 0; m_res = 0; m_sum = 0; m_cnt = 0;
      m_upd = 0; m_pend = 0; started = 1;
    end else begin
      if (acc_we != 2'b00) begin
        logic [15:0] t;
        t = m_acc[15:0];
        if (acc_we[1]) t[15:8] = acc_wdata[15:8];
        if (acc_we[0]) t[7:0]  = acc_wdata[7:0];
        m_acc = $signed(t);
      end else if (m_pend) begin
        int tot, st;
        tot = m_res + m_cur * SC;
        st = tot >>> FR;
        m_res = tot - st * (1 << FR);
        m_acc = m_acc + st;
        if (m_acc > 32767) m_acc = 32767;
        if (m_acc < -32768) m_acc = -32768;
      end
      m_upd = m_pend ? 1 : 0;
      m_pend = 0;
      if (s_valid) begin
        int d;
        d = $signed(s_data);
        m_sum += d;
        m_cnt++;
        if (m_cnt == (1 << NL)) begin
          int v, b;
          b = $signed(bias);
          v = (m_sum >>> NL) - b;
          if (v > 2047) v = 2047;
          if (v < -2048) v = -2048;
          m_cur = v; m_pend = 1; m_sum = 0; m_cnt = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 cur_out vs model", $signed(cur_out), m_cur);
      chk("R6 acc_out vs model", $signed(acc_out), m_acc);
      chk("R5 upd vs model", int'(upd), m_upd);
      chk("R10 s_ready", int'(s_ready), rst ? 0 : 1);
    end
  end

  task automatic push(input int d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data = d[13:0];
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  task automatic blk(input int d0, input int d1, input int gap);
    for (int i = 0; i < (1 << NL); i++) begin
      push((i % 2) ? d1 : d0);
      if (gap != 0 && (i % 3) == 1) idle(gap);
    end
    idle(1);
  endtask

  task automatic wr(input logic [1:0] we, input logic [15:0] d);
    @(negedge clk);
    acc_we = we;
    acc_wdata = d;
    @(negedge clk);
    acc_we = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cur in reset", int'(cur_out), 0);
    chk("R1 acc in reset", int'(acc_out), 0);
    chk("R1 upd in reset", int'(upd), 0);
    chk("R10 ready low in reset", int'(s_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 acc after reset", int'(acc_out), 0);
    chk("R10 ready after reset", int'(s_ready), 1);

    // R6: residue carry, 16 unit-current updates add exactly 45
    for (int k = 0; k < 16; k++) blk(1, 1, 0);
    idle(1);
    chk("R6 residue exact sum", $signed(acc_out), 45);

    // R8: byte writes
    wr(2'b10, 16'hAB00);
    chk("R8 msb write", int'(acc_out), 32'hAB2D);
    wr(2'b01, 16'h0077);
    chk("R8 lsb write", int'(acc_out), 32'hAB77);

    // R3: floor of a negative average
    blk(5, -6, 1);
    chk("R3 floor average", $signed(cur_out), -1);
    bias = 8'sd3;
    blk(100, 100, 0);
    chk("R3 bias subtract", $signed(cur_out), 97);

    // R9: host write collides with integration
    bias = 8'sd0;
    blk(1000, 1000, 0);
    acc_we = 2'b11;
    acc_wdata = 16'h0100;
    @(negedge clk);
    acc_we = 2'b00;
    chk("R9 write wins", int'(acc_out), 32'h0100);
    chk("R9 upd still pulses", int'(upd), 1);

    // R2: partial block leaves cur_out alone
    for (int i = 0; i < 7; i++) push(500);
    idle(10);
    chk("R2 partial block holds", $signed(cur_out), 1000);
    push(500);
    idle(1);
    chk("R2 completes on 8th sample", $signed(cur_out), 500);

    // R4: clamps
    bias = -8'sd20;
    blk(2040, 2040, 0);
    chk("R4 bias pushes over max", $signed(cur_out), 2047);
    bias = 8'sd10;
    blk(-2048, -2048, 2);
    chk("R4 bias pushes under min", $signed(cur_out), -2048);

    // R7: saturation both ways
    bias = 8'sd0;
    wr(2'b11, 16'h7FBC);
    blk(4000, 4000, 0);
    idle(1);
    chk("R4 large positive", $signed(cur_out), 2047);
    chk("R7 positive saturation", $signed(acc_out), 32767);
    blk(8191, 8191, 0);
    idle(1);
    chk("R7 stays at max", $signed(acc_out), 32767);
    wr(2'b11, 16'h8044);
    blk(-8000, -8000, 1);
    idle(1);
    chk("R7 negative saturation", $signed(acc_out), -32768);

    // Mixed traffic checked by the reference every cycle
    for (int k = 0; k < 40; k++) begin
      bias = 8'($urandom_range(0, 255));
      for (int i = 0; i < (1 << NL); i++) begin
        push(int'($urandom_range(0, 16383)) - 8192);
        if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
      end
      if (k % 7 == 3) begin
        @(negedge clk);
        acc_we = 2'($urandom_range(1, 3));
        acc_wdata = 16'($urandom);
        s_valid = 1'b0;
        @(negedge clk);
        acc_we = 2'b00;
      end
    end
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule